// File: doc/BRIEF.md
# Parallel Port Mode Control and FIFO Status

This block is the mode-control and FIFO-status part of an IEEE 1284-style parallel port. It sits behind a byte-wide register bus. It holds a 3-bit operating-mode field and a 16-byte data FIFO shared between the host and the peripheral side. It reports three flags: empty, full and service-request. The transfer direction input, taken from the device control register, decides which side fills the FIFO and which side drains it. It also decides what the service-request flag measures.

With the direction bit low, the host writes bytes into the FIFO through the data offset and the peripheral side pops them. With the direction bit high, the peripheral side pushes and host reads of the data offset pop. A read-only configuration register carrying the registered interrupt state is visible only while the mode field selects the configuration code. Any change of the mode field empties the FIFO.

Top module: `pp_xctl`

## Requirements
- R1: After reset the mode field is 000, the FIFO is empty, a read of offset 2 returns 0x05 and `irq_o` is 0.
- R2: A host write to offset 2 stores `reg_wdata[7:5]` as the mode, and every code 000 to 111 is stored as written. Reads of offset 2 return the mode in bits 7:5 and 0 in bits 4:3. Written bits 4:0 have no effect on any state.
- R3: Bit 0 of offset 2 (empty) is 1 exactly when the FIFO holds no byte, for either direction.
- R4: Bit 1 of offset 2 (full) is 1 exactly when the FIFO holds 16 bytes, for either direction.
- R5: Bit 2 of offset 2 (service) is 1 under one of two conditions. With `dir_rev`=0 it needs at least 8 free entries. With `dir_rev`=1 it needs at least 8 filled entries.
- R6: With `dir_rev`=0, host writes to offset 0 push and `per_pop` pops, while host reads of offset 0 return 0. With `dir_rev`=1, `per_push` pushes, and a host read of offset 0 pops and returns the oldest byte in the same cycle. Bytes leave in arrival order, and `per_rdata` shows the oldest byte, or 0 when empty.
- R7: A push into a full FIFO and a pop from an empty FIFO are ignored, and the stored bytes and count are unchanged. A push or pop strobe from the side the direction does not select is also ignored.
- R8: A write to offset 2 whose mode differs from the stored mode empties the FIFO at that edge, and any push or pop in that cycle is dropped. Rewriting the same mode keeps the contents.
- R9: `irq_o` is registered. On each edge it takes the value (service flag AND `irq_en`) as it stood just before that edge.
- R10: A read of offset 1 returns `irq_o` in bit 6 and 0 elsewhere, but only while the mode is 111. Otherwise it reads 0. Offsets 3 to 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| reg_addr | input | 3 | Register offset in the upper block |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (pops at offset 0 when `dir_rev`=1) |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| dir_rev | input | 1 | Transfer direction: 0 host to peripheral, 1 peripheral to host |
| irq_en | input | 1 | Interrupt enable |
| per_push | input | 1 | Peripheral push strobe |
| per_wdata | input | 8 | Peripheral push data |
| per_pop | input | 1 | Peripheral pop strobe |
| per_rdata | output | 8 | Oldest FIFO byte, 0 when empty |
| irq_o | output | 1 | Registered service interrupt |

## Verification
The assertions assume that the host never raises `reg_wr` and `reg_rd` in the same cycle, and that `reg_addr` is stable while a strobe is high. They do not assume a steady `dir_rev`, so the direction may flip with bytes still in the FIFO. The stimulus keeps host strobes mutually exclusive and changes direction and enable only between cycles. Mode writes are kept rare, so that the random traffic still reaches the full and half-full thresholds. Directed passes cover the threshold boundaries, overflow, underflow, flush on mode change and the configuration gate.

// File: rtl/pp_xctl_pkg.sv
package pp_xctl_pkg;
  typedef enum logic [2:0] {
    MODE_COMPAT = 3'b000,
    MODE_BYTE   = 3'b001,
    MODE_RSV_A  = 3'b010,
    MODE_EXTCAP = 3'b011,
    MODE_ENH    = 3'b100,
    MODE_RSV_B  = 3'b101,
    MODE_TEST   = 3'b110,
    MODE_CFG    = 3'b111
  } pp_mode_e;

  localparam int OFF_DATA = 0;
  localparam int OFF_CFGB = 1;
  localparam int OFF_CTL  = 2;
  localparam int CFG_IRQ_BIT = 6;
endpackage

// File: rtl/pp_xctl_fifo.sv
module pp_xctl_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [DW-1:0]    wdata,
  input  logic             pop,
  output logic [DW-1:0]    rdata,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop, mem_we;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == DEPTH_C);
  assign count   = cnt_q;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign mem_we  = do_push && !flush;
  assign rdata   = empty ? '0 : mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = ptr_inc(wr_q);
      if (do_pop)  rd_d = ptr_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem_q[wr_q] <= wdata;
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_C);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (cnt_q == $past(cnt_q)));
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> empty);
  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/pp_xctl_mode.sv
module pp_xctl_mode
  import pp_xctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic [2:0] wr_mode,
  output pp_mode_e mode,
  output logic     flush
);
  pp_mode_e mode_q, mode_d;

  assign flush = wr_en && (pp_mode_e'(wr_mode) != mode_q);

  always_comb begin
    mode_d = mode_q;
    if (wr_en) mode_d = pp_mode_e'(wr_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_COMPAT;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_q));
endmodule

// File: rtl/pp_xctl.sv
module pp_xctl
  import pp_xctl_pkg::*;
#(
  parameter int AW     = 3,
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int THRESH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          dir_rev,
  input  logic          irq_en,
  input  logic          per_push,
  input  logic [DW-1:0] per_wdata,
  input  logic          per_pop,
  output logic [DW-1:0] per_rdata,
  output logic          irq_o
);
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam logic [CNT_W-1:0] FREE_LIM = CNT_W'(DEPTH - THRESH);
  localparam logic [CNT_W-1:0] FILL_LIM = CNT_W'(THRESH);

  pp_mode_e         mode;
  logic             flush, ctl_we, at_data;
  logic             f_push, f_pop, f_empty, f_full, svc;
  logic [DW-1:0]    f_wdata, f_rdata;
  logic [CNT_W-1:0] f_count;
  logic             irq_q, irq_d;

  assign at_data = (reg_addr == AW'(OFF_DATA));
  assign ctl_we  = reg_wr && (reg_addr == AW'(OFF_CTL));
  assign f_push  = dir_rev ? per_push : (reg_wr && at_data);
  assign f_wdata = dir_rev ? per_wdata : reg_wdata;
  assign f_pop   = dir_rev ? (reg_rd && at_data) : per_pop;

  pp_xctl_mode mode_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_we),
    .wr_mode (reg_wdata[DW-1 -: 3]),
    .mode    (mode),
    .flush   (flush)
  );

  pp_xctl_fifo #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (f_push),
    .wdata (f_wdata),
    .pop   (f_pop),
    .rdata (f_rdata),
    .count (f_count),
    .empty (f_empty),
    .full  (f_full)
  );

  assign svc   = dir_rev ? (f_count >= FILL_LIM) : (f_count <= FREE_LIM);
  assign irq_d = svc && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o     = irq_q;
  assign per_rdata = f_rdata;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(OFF_DATA): reg_rdata = dir_rev ? f_rdata : '0;
      AW'(OFF_CFGB): if (mode == MODE_CFG) reg_rdata[CFG_IRQ_BIT] = irq_q;
      AW'(OFF_CTL):  reg_rdata = {mode, {(DW-6){1'b0}}, svc, f_full, f_empty};
      default:       reg_rdata = '0;
    endcase
  end

  // R3
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_empty |-> !f_full);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq_o);
  // R10
  cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr == AW'(OFF_CFGB)) && (mode != MODE_CFG)) |-> (reg_rdata == '0));
endmodule

// File: tb/pp_xctl_tb_top.sv
module pp_xctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       dir_rev, irq_en;
  logic       per_push, per_pop;
  logic [7:0] per_wdata, per_rdata;
  logic       irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] q_m[$];
  logic [2:0] mode_m;
  logic       irq_m;

  always #2 clk = ~clk;

  pp_xctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dir_rev(dir_rev), .irq_en(irq_en), .per_push(per_push),
    .per_wdata(per_wdata), .per_pop(per_pop), .per_rdata(per_rdata),
    .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic svc_m();
    int n = q_m.size();
    return dir_rev ? (n >= 8) : ((16 - n) >= 8);
  endfunction

  function automatic logic [7:0] head_m();
    return (q_m.size() > 0) ? q_m[0] : 8'h00;
  endfunction

  function automatic logic [7:0] rd_exp(input logic [2:0] a);
    case (a)
      3'd0:    return dir_rev ? head_m() : 8'h00;
      3'd1:    return (mode_m == 3'b111) ? {1'b0, irq_m, 6'b0} : 8'h00;
      3'd2:    return {mode_m, 2'b00, svc_m(), (q_m.size() == 16), (q_m.size() == 0)};
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(input string tag);
    logic [7:0] e;
    bit push_ok, pop_ok, flush;
    #1;
    chk(per_rdata === head_m(), "R6", per_rdata, head_m());
    chk(irq_o === irq_m, "R9", irq_o, irq_m);
    if (reg_rd) begin
      e = rd_exp(reg_addr);
      chk(reg_rdata === e, tag, reg_rdata, e);
    end
    @(posedge clk);
    irq_m = svc_m() && irq_en;
    flush = reg_wr && (reg_addr == 3'd2) && (reg_wdata[7:5] != mode_m);
    if (reg_wr && reg_addr == 3'd2) mode_m = reg_wdata[7:5];
    if (flush) q_m.delete();
    else begin
      push_ok = (dir_rev ? per_push : (reg_wr && reg_addr == 3'd0)) && (q_m.size() < 16);
      pop_ok  = (dir_rev ? (reg_rd && reg_addr == 3'd0) : per_pop) && (q_m.size() > 0);
      if (pop_ok) void'(q_m.pop_front());
      if (push_ok) q_m.push_back(dir_rev ? per_wdata : reg_wdata);
    end
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; per_push = 0; per_pop = 0;
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    step("R6");
  endtask

  task automatic host_rd(input logic [2:0] a, input string tag);
    reg_addr = a; reg_rd = 1;
    step(tag);
  endtask

  task automatic per_in(input logic [7:0] d);
    per_wdata = d; per_push = 1;
    step("R6");
  endtask

  task automatic per_out();
    per_pop = 1;
    step("R6");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; reg_addr = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    dir_rev = 0; irq_en = 0; per_push = 0; per_wdata = 0; per_pop = 0;
    mode_m = 3'b000; irq_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    reg_addr = 3'd2;
    #1;
    // R1 reset state
    chk(reg_rdata === 8'h05, "R1", reg_rdata, 8'h05);
    chk(irq_o === 1'b0, "R1", irq_o, 0);
    @(negedge clk);

    // R2 mode store, low bits ignored
    host_wr(3'd2, 8'h61);
    host_rd(3'd2, "R2");
    host_wr(3'd2, 8'h7F);
    host_rd(3'd2, "R2");
    for (int m = 0; m < 8; m++) begin
      host_wr(3'd2, {m[2:0], 5'b00001});
      host_rd(3'd2, "R2");
    end
    host_wr(3'd2, 8'h61);

    // R3 R4 R5 fill in host-write direction, crossing the threshold
    for (int i = 0; i < 16; i++) begin
      host_wr(3'd0, 8'hA0 + i[7:0]);
      host_rd(3'd2, "R3/R4/R5");
    end
    // R7 overflow ignored
    host_wr(3'd0, 8'hEE);
    host_rd(3'd2, "R7");
    host_rd(3'd0, "R6");
    // R6 peripheral drains in order
    for (int i = 0; i < 9; i++) per_out();
    host_rd(3'd2, "R5");
    // R9 enable
    irq_en = 1;
    step("R9"); step("R9");
    host_rd(3'd2, "R9");
    // R8 same-mode rewrite keeps data, change flushes
    host_wr(3'd2, 8'h61);
    host_rd(3'd2, "R8");
    host_wr(3'd2, 8'hE1);
    host_rd(3'd2, "R8");
    // R10 config register gate
    step("R10");
    host_rd(3'd1, "R10");
    host_rd(3'd5, "R10");
    host_wr(3'd2, 8'hC1);
    host_rd(3'd1, "R10");
    // R7 underflow ignored
    per_out();
    host_rd(3'd2, "R7");
    // R6 reverse direction
    dir_rev = 1;
    for (int i = 0; i < 20; i++) per_in(8'h30 + i[7:0]);
    host_rd(3'd2, "R4");
    for (int i = 0; i < 17; i++) host_rd(3'd0, "R6");
    host_rd(3'd2, "R3");
    host_wr(3'd0, 8'h55);
    host_rd(3'd2, "R7");

    // random traffic
    for (int n = 0; n < 6000; n++) begin
      int r = $urandom_range(0, 99);
      if ($urandom_range(0, 199) == 0) dir_rev = ~dir_rev;
      if ($urandom_range(0, 99) == 0)  irq_en  = ~irq_en;
      per_wdata = 8'($urandom);
      per_push  = ($urandom_range(0, 2) == 0);
      per_pop   = ($urandom_range(0, 2) == 0);
      if (r < 30) begin
        reg_addr = 3'd0; reg_wdata = 8'($urandom); reg_wr = 1;
      end else if (r < 55) begin
        reg_addr = 3'd0; reg_rd = 1;
      end else if (r < 80) begin
        reg_addr = 3'd2; reg_rd = 1;
      end else if (r < 88) begin
        reg_addr = 3'($urandom_range(1, 7)); reg_rd = 1;
      end else if (r < 90) begin
        reg_addr = 3'd2;
        reg_wdata = {($urandom_range(0, 3) == 0) ? 3'b111 : mode_m, 5'($urandom)};
        reg_wr = 1;
      end
      step("R2/R3/R4/R5/R10");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule